// File: doc/BRIEF.md
# Trigger Stub Synchronization Validator

The block sits at the entry of a trigger processor and checks that every incoming trigger stub belongs to the bunch crossing the processor believes it is in. A stub is 32 bits wide and arrives as two 16-bit frames on consecutive clock cycles, so one bunch crossing takes two clocks. The block keeps its own bunch-crossing counter, which a control-board reset input re-aligns. It compares the bunch-zero marker carried inside the stub and the bunch-zero pulse from the control board with the moment its counter is at zero. It also compares the stub's crossing-parity bit with the counter's least significant bit.

A bunch-zero disagreement is treated as a lasting loss of alignment: from that stub on, every stub leaves with its sync-error bit set until the counter is reset again. A parity disagreement marks only the stub concerned. Two control bits choose whether a flagged stub also loses its valid bit and whether its quality field is zeroed. Flagged stubs are counted in a saturating counter, and an out-of-sync flag is raised while that count is above a writable threshold.

Top module: `stub_sync_check`

## Requirements
- R1: A local crossing counter advances once per crossing (every two clocks), runs from 0 to BX_LAST (default 3563) and then returns to 0; the BX counter reset input and the chip reset set it to 0 with the next frame taken as a first frame.
- R2: The first frame forms stub bits 31:16 and the second frame bits 15:0; fields are valid bit 31, quality bits 30:27, bunch-zero flag bit 11, crossing-parity bit 10, sync-error bit 9. The processed stub appears on `stub_o` with `stub_vld_o` high for exactly one clock, the clock after the second frame; a stub with no mismatch and sync-error 0 passes unchanged.
- R3: If the stub's bit 11 differs from (counter == 0), or a control-board pulse seen during either frame of the crossing differs from (counter == 0), the stub gets bit 9 set and so does every later stub until the BX counter reset or chip reset.
- R4: If the stub's bit 10 differs from the counter's LSB, that stub alone gets bit 9 set.
- R5: When the outgoing bit 9 is 1 and control bit 0 is 1, outgoing bit 31 is 0; otherwise bit 31 passes through.
- R6: When the outgoing bit 9 is 1 and control bit 1 is 1, outgoing bits 30:27 are 0; otherwise they pass through.
- R7: `err_cnt_o` counts every outgoing stub with bit 9 set, whether it arrived set or was set locally, and saturates at its all-ones value; it changes on the same clock as the stub appears.
- R8: `oos_o` is high exactly while `err_cnt_o` is greater than the threshold register; the threshold resets to THR_RESET (default 8).
- R9: A write with `wr_sel_i`=0 loads the control bits from `wr_data_i[1:0]`; with `wr_sel_i`=1 it loads the threshold from the low CNT_W bits; both reset to their defaults with `rst_n` and are not changed by the BX counter reset.
- R10: The BX counter reset clears the sticky error, the error count and `oos_o` and drops `stub_vld_o` on the next clock; after chip reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock, two clocks per crossing |
| rst_n | input | 1 | Active-low synchronous chip reset |
| frame_i | input | 16 | Stub frame, first then second half |
| ccb_bc0_i | input | 1 | Bunch-zero pulse from the control board |
| bx_rst_i | input | 1 | Crossing counter and error state reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects control bits, 1 selects threshold |
| wr_data_i | input | 16 | Register write data |
| stub_o | output | 32 | Processed stub |
| stub_vld_o | output | 1 | One-clock strobe marking a new stub |
| err_cnt_o | output | CNT_W | Saturating count of flagged stubs |
| oos_o | output | 1 | Error count above threshold |

## Verification
A counter that has slipped by one crossing shows on the very next stub as a parity flag in bit 9, and within one orbit as a permanent flag once the bunch-zero check fails. A lost or spurious sticky state shows as a wrong bit 9 one clock after the second frame of the next crossing, and also as an error count that stops or keeps growing. A frame-phase slip shows at once as stubs with swapped halves and a strobe on the wrong clock.

// File: rtl/stub_sync_check.sv
module stub_sync_check #(
  parameter int BX_LAST   = 3563,
  parameter int BX_W      = 12,
  parameter int CNT_W     = 16,
  parameter int THR_RESET = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      frame_i,
  input  logic             ccb_bc0_i,
  input  logic             bx_rst_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [15:0]      wr_data_i,
  output logic [31:0]      stub_o,
  output logic             stub_vld_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic             oos_o
);
  logic             phase;
  logic [15:0]      hi_q;
  logic             ccb_lat;
  logic [BX_W-1:0]  bx;
  logic             sticky;
  logic [1:0]       ctl;
  logic [CNT_W-1:0] thr;

  wire [31:0] raw     = {hi_q, frame_i};
  wire        at_zero = (bx == '0);
  wire        ccb_hit = ccb_bc0_i | ccb_lat;
  wire        bc0_bad = (raw[11] != at_zero) | (ccb_hit != at_zero);
  wire        bx0_bad = (raw[10] != bx[0]);
  wire        se      = raw[9] | bc0_bad | bx0_bad | sticky;
  wire        vp      = raw[31] & ~(se & ctl[0]);
  wire [3:0]  qual    = (se & ctl[1]) ? 4'd0 : raw[30:27];
  wire [31:0] fixed   = {vp, qual, raw[26:10], se, raw[8:0]};

  assign oos_o = err_cnt_o > thr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= 1'b0;
      hi_q       <= '0;
      ccb_lat    <= 1'b0;
      bx         <= '0;
      sticky     <= 1'b0;
      ctl        <= '0;
      thr        <= CNT_W'(THR_RESET);
      err_cnt_o  <= '0;
      stub_o     <= '0;
      stub_vld_o <= 1'b0;
    end else begin
      if (wr_en_i) begin
        if (wr_sel_i) thr <= wr_data_i[CNT_W-1:0];
        else          ctl <= wr_data_i[1:0];
      end
      if (bx_rst_i) begin
        phase      <= 1'b0;
        ccb_lat    <= 1'b0;
        bx         <= '0;
        sticky     <= 1'b0;
        err_cnt_o  <= '0;
        stub_vld_o <= 1'b0;
      end else begin
        stub_vld_o <= phase;
        if (!phase) begin
          phase   <= 1'b1;
          hi_q    <= frame_i;
          ccb_lat <= ccb_bc0_i;
        end else begin
          phase   <= 1'b0;
          ccb_lat <= 1'b0;
          stub_o  <= fixed;
          bx      <= (bx == BX_W'(BX_LAST)) ? '0 : bx + 1'b1;
          sticky  <= sticky | bc0_bad;
          if (se && !(&err_cnt_o)) err_cnt_o <= err_cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/stub_sync_check_sva.sv
module stub_sync_check_sva #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bx_rst_i,
  input logic             wr_en_i,
  input logic [1:0]       ctl,
  input logic [31:0]      stub_o,
  input logic             stub_vld_o,
  input logic [CNT_W-1:0] err_cnt_o,
  input logic             oos_o
);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stub_vld_o |=> !stub_vld_o);

  p_vp_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stub_vld_o && stub_o[9] && ctl[0]) |-> !stub_o[31]);

  p_qual_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stub_vld_o && stub_o[9] && ctl[1]) |-> (stub_o[30:27] == 4'd0));

  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_rst_i |=> (err_cnt_o == $past(err_cnt_o)) || (err_cnt_o == $past(err_cnt_o) + 1'b1));

  p_cnt_follows_se_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bx_rst_i |=> ($rose(stub_vld_o) && stub_o[9] && !(&$past(err_cnt_o)))
                  -> (err_cnt_o == $past(err_cnt_o) + 1'b1));

  p_oos_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oos_o && !bx_rst_i && !wr_en_i) |=> oos_o);

  p_bxrst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bx_rst_i |=> (err_cnt_o == '0) && !oos_o && !stub_vld_o);
endmodule

bind stub_sync_check stub_sync_check_sva #(.CNT_W(CNT_W)) i_sva (
  .clk(clk), .rst_n(rst_n), .bx_rst_i(bx_rst_i), .wr_en_i(wr_en_i), .ctl(ctl),
  .stub_o(stub_o), .stub_vld_o(stub_vld_o), .err_cnt_o(err_cnt_o), .oos_o(oos_o)
);

// File: tb/test_stub_sync_check.sv
module test_stub_sync_check;
  localparam int BX_LAST = 23;
  localparam int CNT_W   = 6;
  localparam int THR_DEF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [15:0] frame_i = '0;
  logic ccb_bc0_i = 1'b0, bx_rst_i = 1'b0, wr_en_i = 1'b0, wr_sel_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [31:0] stub_o;
  logic stub_vld_o, oos_o;
  logic [CNT_W-1:0] err_cnt_o;

  always #10 clk = ~clk;

  stub_sync_check #(.BX_LAST(BX_LAST), .BX_W(12), .CNT_W(CNT_W), .THR_RESET(THR_DEF)) i_stub_sync_check (
    .clk(clk), .rst_n(rst_n), .frame_i(frame_i), .ccb_bc0_i(ccb_bc0_i), .bx_rst_i(bx_rst_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i),
    .stub_o(stub_o), .stub_vld_o(stub_vld_o), .err_cnt_o(err_cnt_o), .oos_o(oos_o));

  int checks = 0, fails = 0;
  int mbx = 0, mcnt = 0, mthr = THR_DEF;
  bit msticky = 0;
  bit [1:0] mctl = 0;
  bit pend = 0, psel = 0;
  bit [15:0] pdat = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit [31:0] good_stub();
    bit [31:0] s = $urandom;
    s[11] = (mbx == 0);
    s[10] = mbx[0];
    s[9]  = 1'b0;
    return s;
  endfunction

  task automatic wr(input bit sel, input bit [15:0] d);
    pend = 1; psel = sel; pdat = d;
  endtask

  task automatic xing(input bit [31:0] s, input bit ccb, input string req);
    bit [31:0] e;
    bit bc0b, se;
    if (pend) begin
      wr_en_i = 1; wr_sel_i = psel; wr_data_i = pdat;
      if (psel) mthr = pdat[CNT_W-1:0]; else mctl = pdat[1:0];
      pend = 0;
    end
    frame_i = s[31:16]; ccb_bc0_i = 1'b0;
    @(negedge clk);
    wr_en_i = 0;
    frame_i = s[15:0]; ccb_bc0_i = ccb;
    @(negedge clk);
    ccb_bc0_i = 1'b0;
    bc0b = (s[11] != (mbx == 0)) || (ccb != (mbx == 0));
    se = s[9] || bc0b || (s[10] != mbx[0]) || msticky;
    e = s;
    e[9] = se;
    if (se && mctl[0]) e[31] = 1'b0;
    if (se && mctl[1]) e[30:27] = 4'd0;
    if (se && mcnt < (1 << CNT_W) - 1) mcnt++;
    msticky = msticky || bc0b;
    mbx = (mbx == BX_LAST) ? 0 : mbx + 1;
    chk({req, " stub"}, stub_o, e);
    chk("R2 strobe", stub_vld_o, 1'b1);
    chk("R7 count", err_cnt_o, mcnt);
    chk("R8 oos", oos_o, mcnt > mthr);
  endtask

  task automatic bxrst();
    bx_rst_i = 1'b1;
    @(negedge clk);
    bx_rst_i = 1'b0;
    mbx = 0; msticky = 0; mcnt = 0;
    chk("R10 count cleared", err_cnt_o, 0);
    chk("R10 oos cleared", oos_o, 0);
    chk("R10 strobe low", stub_vld_o, 0);
  endtask

  initial begin
    int n = 0;
    while (!done && n < 200000) begin @(posedge clk); n++; end
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<200000", n);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit [31:0] s;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 reset stub", stub_o, 0);
    chk("R10 reset strobe", stub_vld_o, 0);
    chk("R10 reset count", err_cnt_o, 0);
    chk("R10 reset oos", oos_o, 0);
    rst_n = 1'b1;

    // R1 R2: clean stubs across two counter wraps
    for (int i = 0; i < 2 * (BX_LAST + 1) + 3; i++) xing(good_stub(), mbx == 0, "R1 R2 clean");
    @(negedge clk);
    chk("R2 strobe gap", stub_vld_o, 0);
    frame_i = '0;
    // realign: the extra negedge spent one frame slot
    bxrst();

    // R7: incoming sync error counted, VP kept with ctl=0
    for (int i = 0; i < 3; i++) begin s = good_stub(); s[9] = 1; s[31] = 1; xing(s, mbx == 0, "R7 incoming"); end

    // R4 R5 R6: parity mismatch with both control bits set
    wr(1'b0, 16'h0003);
    s = good_stub(); s[10] = ~s[10]; s[31] = 1; s[30:27] = 4'hA;
    xing(s, mbx == 0, "R4 R5 R6 parity");
    chk("R5 vp cleared", stub_o[31], 0);
    chk("R6 quality zero", stub_o[30:27], 0);
    xing(good_stub(), mbx == 0, "R4 not sticky");
    chk("R4 next clean", stub_o[9], 0);

    // R8 R9: threshold lowered to 2
    wr(1'b1, 16'd2);
    s = good_stub(); s[9] = 1; xing(s, mbx == 0, "R8 R9 threshold");
    chk("R8 above threshold", oos_o, 1);

    // R10 R9: bx reset keeps control bits
    bxrst();
    s = good_stub(); s[9] = 1; s[31] = 1; xing(s, mbx == 0, "R9 ctl kept");
    chk("R9 vp still gated", stub_o[31], 0);

    // R3: data bunch-zero missing at counter zero -> sticky
    bxrst();
    s = good_stub(); s[11] = 0; xing(s, 1'b1, "R3 data bc0");
    for (int i = 0; i < 5; i++) begin xing(good_stub(), mbx == 0, "R3 sticky"); chk("R3 held", stub_o[9], 1); end
    bxrst();
    xing(good_stub(), 1'b1, "R3 after reset");
    chk("R3 cleared", stub_o[9], 0);

    // R3: control-board pulse on wrong crossing
    xing(good_stub(), 1'b1, "R3 ccb spurious");
    chk("R3 ccb flagged", stub_o[9], 1);
    bxrst();
    // R3: control-board pulse missing at zero
    xing(good_stub(), 1'b0, "R3 ccb missing");
    chk("R3 ccb missing flagged", stub_o[9], 1);

    // R7: saturation
    for (int i = 0; i < 70; i++) xing(good_stub(), mbx == 0, "R7 saturate");
    chk("R7 saturated", err_cnt_o, (1 << CNT_W) - 1);

    // random mix
    bxrst();
    wr(1'b1, 16'd20);
    for (int i = 0; i < 400; i++) begin
      bit ccb;
      s = good_stub();
      if ($urandom_range(15) == 0) s[10] = ~s[10];
      if ($urandom_range(15) == 0) s[9] = 1;
      if ($urandom_range(63) == 0) s[11] = ~s[11];
      ccb = (mbx == 0);
      if ($urandom_range(63) == 0) ccb = ~ccb;
      if ($urandom_range(31) == 0) wr(1'b0, 16'($urandom_range(3)));
      xing(s, ccb, "R3 R4 R5 R6 random");
      if ($urandom_range(99) == 0) bxrst();
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule